// File: doc/BRIEF.md
# Sixteen-Function 4-Bit Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit. It takes two operands, a carry input and a four-bit function code. It returns a result of the operand width and a sign indication equal to the result's top bit. Ten function codes cover bitwise logic and pass-through. The other six cover increment, decrement and addition, and they share one adder.

A small sequencer drives the block. The sequencer loads operands into its own registers, picks a function code each cycle and reads the sign output to make decisions such as taking an absolute value. The unit has no direct subtract code. A controller computes a minus b by first inverting b and then adding with the carry input set.

The operand width is a parameter with a default of 4. A second parameter chooses between a behavioural adder and an explicit ripple-carry chain.

Top module: `alu4_top`

## Requirements
- R1: Code 0000 gives y = NOT a, and code 0001 gives y = NOT b.
- R2: Codes 0010, 0011, 0100, 0101, 0110 and 0111 give a AND b, a OR b, a NAND b, a NOR b, a XOR b and a XNOR b, in that order.
- R3: Code 1000 gives y = a unchanged, and code 1001 gives y = b unchanged.
- R4: Code 1010 gives a+1 and code 1011 gives b+1, modulo 16, so an input of 1111 yields 0000.
- R5: Code 1100 gives a-1 and code 1101 gives b-1, modulo 16, so an input of 0000 yields 1111.
- R6: Code 1110 gives a+b modulo 16, and any carry out of bit 3 is dropped.
- R7: Code 1111 gives a+b+cin modulo 16.
- R8: The output neg always equals bit 3 (the most significant bit) of y, for every code.
- R9: For every code other than 1111, cin has no effect on y or neg.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First operand |
| b | input | 4 | Second operand |
| cin | input | 1 | Carry input, used by code 1111 only |
| op | input | 4 | Function code |
| y | output | 4 | Result |
| neg | output | 1 | Sign indication, the top bit of y |

## Verification
The wrap-around of the arithmetic and the sign output take effect together on the same inputs. For example, 0000 minus one gives 1111 and raises neg in the same cycle, and 1000+1000 with its carry dropped gives 0000 and clears neg. The bench walks every combination of function code, operands and carry, and adds directed wrap cases and seeded random vectors. It compares y and neg against its own model at each step. To show that cin has no effect outside code 1111, each vector is applied twice with cin flipped, and the two results must be equal.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
   // Function code encoding; the bit pattern is part of the block's behaviour.
   typedef enum logic [3:0] {
      FN_NOT_A  = 4'h0,
      FN_NOT_B  = 4'h1,
      FN_AND    = 4'h2,
      FN_OR     = 4'h3,
      FN_NAND   = 4'h4,
      FN_NOR    = 4'h5,
      FN_XOR    = 4'h6,
      FN_XNOR   = 4'h7,
      FN_PASS_A = 4'h8,
      FN_PASS_B = 4'h9,
      FN_INC_A  = 4'hA,
      FN_INC_B  = 4'hB,
      FN_DEC_A  = 4'hC,
      FN_DEC_B  = 4'hD,
      FN_ADD    = 4'hE,
      FN_ADDC   = 4'hF
   } fn_code_e;

   localparam int unsigned FN_W = 4;

   typedef enum int unsigned {
      ADDER_BEHAV  = 0,
      ADDER_RIPPLE = 1
   } adder_kind_e;
endpackage

// File: rtl/alu4_logic.sv
module alu4_logic
   import alu4_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  fn_code_e           fn,
   input  logic [WIDTH-1:0]   opa,
   input  logic [WIDTH-1:0]   opb,
   output logic [WIDTH-1:0]   res
);
   always_comb begin
      unique case (fn)
         FN_NOT_A:  res = ~opa;
         FN_NOT_B:  res = ~opb;
         FN_AND:    res = opa & opb;
         FN_OR:     res = opa | opb;
         FN_NAND:   res = ~(opa & opb);
         FN_NOR:    res = ~(opa | opb);
         FN_XOR:    res = opa ^ opb;
         FN_XNOR:   res = ~(opa ^ opb);
         FN_PASS_A: res = opa;
         FN_PASS_B: res = opb;
         default:   res = '0;
      endcase
   end
endmodule

// File: rtl/alu4_adder.sv
module alu4_adder
   import alu4_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned KIND  = ADDER_BEHAV
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] z,
   input  logic             ci,
   output logic [WIDTH-1:0] s
);
   generate
      if (KIND == ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH-1:0] carry;
         assign carry[0] = ci;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign s[i] = x[i] ^ z[i] ^ carry[i];
            if (i < WIDTH - 1) begin : g_c
               assign carry[i+1] = (x[i] & z[i]) | (carry[i] & (x[i] ^ z[i]));
            end
         end
      end else if (KIND == ADDER_BEHAV) begin : g_behav
         assign s = WIDTH'(x + z + WIDTH'(ci));
      end else begin : g_bad_kind
         $error("alu4_adder: unknown KIND");
      end
   endgenerate
endmodule

// File: rtl/alu4_arith.sv
module alu4_arith
   import alu4_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned KIND  = ADDER_BEHAV
) (
   input  fn_code_e         fn,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             cin,
   output logic [WIDTH-1:0] res
);
   logic [WIDTH-1:0] add_x, add_z, pick;
   logic             add_ci;

   // Bit 0 of the code selects the operand for the unary arithmetic codes.
   assign pick = fn[0] ? opb : opa;

   always_comb begin
      add_x  = '0;
      add_z  = '0;
      add_ci = 1'b0;
      unique case (fn)
         FN_INC_A, FN_INC_B: begin add_x = pick; add_ci = 1'b1; end
         FN_DEC_A, FN_DEC_B: begin add_x = pick; add_z = '1; end
         FN_ADD:             begin add_x = opa;  add_z = opb; end
         FN_ADDC:            begin add_x = opa;  add_z = opb; add_ci = cin; end
         default:            ;
      endcase
   end

   alu4_adder #(.WIDTH(WIDTH), .KIND(KIND)) u_add (
      .x  (add_x),
      .z  (add_z),
      .ci (add_ci),
      .s  (res)
   );

   // R9: carry input reaches the adder only for the carry-add code
   always_comb begin
      if (fn != FN_ADDC) a_r9_cin_blocked: assert (add_ci == (fn inside {FN_INC_A, FN_INC_B}));
   end
endmodule

// File: rtl/alu4_top.sv
module alu4_top
   import alu4_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned KIND  = ADDER_BEHAV
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   input  logic [FN_W-1:0]  op,
   output logic [WIDTH-1:0] y,
   output logic             neg
);
   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_chk_width
         $error("alu4_top: WIDTH must be at least 2");
      end
   endgenerate

   fn_code_e         fn;
   logic [WIDTH-1:0] logic_res, arith_res;
   logic             use_arith;

   assign fn        = fn_code_e'(op);
   assign use_arith = op[3] & (op[2] | op[1]);

   alu4_logic #(.WIDTH(WIDTH)) u_logic (
      .fn  (fn),
      .opa (a),
      .opb (b),
      .res (logic_res)
   );

   alu4_arith #(.WIDTH(WIDTH), .KIND(KIND)) u_arith (
      .fn  (fn),
      .opa (a),
      .opb (b),
      .cin (cin),
      .res (arith_res)
   );

   assign y   = use_arith ? arith_res : logic_res;
   assign neg = y[MSB];

   always_comb begin
      if (fn == FN_NOT_A)  a_r1_not_a:  assert (neg == !a[MSB]);
      if (fn == FN_PASS_B) a_r3_pass_b: assert (y == b);
      if (fn == FN_INC_A)  a_r4_inc_a:  assert (y == a + WIDTH'(1));
      if (fn == FN_DEC_B)  a_r5_dec_b:  assert (y == b - WIDTH'(1));
      if (fn == FN_ADD)    a_r6_add:    assert (y == a + b);
      if (fn == FN_ADDC)   a_r7_addc:   assert (y == a + b + WIDTH'(cin));
   end
endmodule

// File: tb/alu4_top_tb.sv
module alu4_top_tb;
   logic       clk = 1'b0;
   logic [3:0] a = '0, b = '0, op = '0;
   logic       cin = 1'b0;
   logic [3:0] y;
   logic       neg;
   int         n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   alu4_top u_dut (.a(a), .b(b), .cin(cin), .op(op), .y(y), .neg(neg));

   function automatic logic [3:0] ref_y(input logic [3:0] o, x, z, input logic c);
      case (o)
         4'h0: return ~x;
         4'h1: return ~z;
         4'h2: return x & z;
         4'h3: return x | z;
         4'h4: return ~(x & z);
         4'h5: return ~(x | z);
         4'h6: return x ^ z;
         4'h7: return ~(x ^ z);
         4'h8: return x;
         4'h9: return z;
         4'hA: return x + 4'd1;
         4'hB: return z + 4'd1;
         4'hC: return x - 4'd1;
         4'hD: return z - 4'd1;
         4'hE: return x + z;
         default: return x + z + {3'b000, c};
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] o);
      if (o < 4'h2) return "R1";
      if (o < 4'h8) return "R2";
      if (o < 4'hA) return "R3";
      if (o < 4'hC) return "R4";
      if (o < 4'hE) return "R5";
      if (o == 4'hE) return "R6";
      return "R7";
   endfunction

   task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s op=%h a=%h b=%h cin=%b: got %h expected %h", req, op, a, b, cin, got, exp);
      end
   endtask

   task automatic apply(input logic [3:0] o, x, z, input logic c);
      @(posedge clk);
      op = o; a = x; b = z; cin = c;
      @(negedge clk);
   endtask

   task automatic run_vec(input logic [3:0] o, x, z, input logic c);
      logic [3:0] e;
      apply(o, x, z, c);
      e = ref_y(o, x, z, c);
      check(req_of(o), y, e);
      check("R8", {3'b000, neg}, {3'b000, e[3]});
   endtask

   // R9: flip cin and expect no change on y and neg
   task automatic run_cin_pair(input logic [3:0] o, x, z);
      logic [3:0] y0;
      logic       n0;
      apply(o, x, z, 1'b0);
      y0 = y; n0 = neg;
      apply(o, x, z, 1'b1);
      check("R9", y, y0);
      check("R9", {3'b000, neg}, {3'b000, n0});
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [3:0] ro, ra, rb;
      logic       rc;
      void'($urandom(32'd1234));
      // initial state: all-zero inputs, code 0000 gives 1111 and neg high (R1, R8)
      @(negedge clk);
      check("R1", y, 4'hF);
      check("R8", {3'b000, neg}, 4'h1);

      // directed wrap corners
      run_vec(4'hA, 4'hF, 4'h0, 1'b0);   // R4 wrap to 0, neg low
      run_vec(4'hB, 4'h0, 4'hF, 1'b1);   // R4
      run_vec(4'hC, 4'h0, 4'h5, 1'b0);   // R5 wrap to F, neg high
      run_vec(4'hD, 4'h3, 4'h0, 1'b1);   // R5
      run_vec(4'hE, 4'h8, 4'h8, 1'b1);   // R6 carry dropped
      run_vec(4'hF, 4'hF, 4'h0, 1'b1);   // R7 wrap with cin
      run_vec(4'hF, 4'h7, 4'h0, 1'b1);   // R7 sign change via cin
      run_vec(4'hF, 4'h5, ~4'h3, 1'b1);  // R7 subtract by invert+carry: 5-3
      check("R7", y, 4'h2);

      // exhaustive sweep
      for (int o = 0; o < 16; o++)
         for (int x = 0; x < 16; x++)
            for (int z = 0; z < 16; z++)
               for (int c = 0; c < 2; c++)
                  run_vec(4'(o), 4'(x), 4'(z), 1'(c));

      // seeded random, plus cin-insensitivity pairs
      for (int i = 0; i < 400; i++) begin
         ro = 4'($urandom); ra = 4'($urandom); rb = 4'($urandom); rc = 1'($urandom);
         run_vec(ro, ra, rb, rc);
         if (ro != 4'hF) run_cin_pair(ro, ra, rb);
      end
      for (int o = 0; o < 15; o++) run_cin_pair(4'(o), 4'h9, 4'h6);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule